// File: doc/BRIEF.md
# Temporal Dither Serializer for One-Bit Colour Lines

This block drives three colour lines, red, green and blue, that are each a single on/off wire. It runs from a clock at four times the pixel rate. On every pixel slot it takes a small intensity code for each channel and sends a four-bit on/off pattern on that channel's line, one bit per fast clock. The number of set bits in the pattern gives five perceived levels: dark, one quarter, one half, three quarters and full. Sync generation stays in the pixel-rate timing logic elsewhere. Only the colour wires run at the fast rate.

The pattern for a partial level is not fixed. A two-bit phase advances once per frame, and the pattern moves its set bits to other positions from frame to frame. Averaged over several frames, each sub-slot position is lit an equal share of the time. The timing logic asserts a strobe once every four fast clocks to mark each pixel slot, and a pulse to mark the start of each frame.

Top module: `dith_rgb_serializer`

## Requirements
- R1: After reset all three colour outputs are 0, and the pattern phase starts at 0.
- R2: Level code 0 gives the pattern 0000 on every phase.
- R3: Level codes 4, 5, 6 and 7 all give the pattern 1111 on every phase.
- R4: Level code 1 gives 1000, 0100, 0010 and 0001 for phases 0, 1, 2 and 3.
- R5: Level code 2 gives 0101 when bit 0 of the phase is 0, and 1010 when it is 1.
- R6: Level code 3 gives 1110, 1101, 1011 and 0111 for phases 0, 1, 2 and 3.
- R7: On the clock edge where the strobe is high, the levels are captured. The leftmost pattern bit drives the output during the next clock, and the remaining three bits follow in order, one per clock.
- R8: Each frame-start pulse advances the phase by one, and the phase wraps from 3 to 0.
- R9: When a frame-start pulse arrives in the same cycle as the strobe, that pixel already uses the advanced phase.
- R10: Each channel's pattern depends only on that channel's level code and the shared phase.
- R11: Once a pixel's four bits have been sent, a channel outputs 0 until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at four times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_stb | input | 1 | Pixel-slot strobe, high for one clock per pixel |
| frame_start | input | 1 | One-clock pulse that marks the start of a frame |
| lvl_r | input | 3 | Red intensity code |
| lvl_g | input | 3 | Green intensity code |
| lvl_b | input | 3 | Blue intensity code |
| col_r | output | 1 | Red on/off line |
| col_g | output | 1 | Green on/off line |
| col_b | output | 1 | Blue on/off line |

## Verification
The phase advance and the pattern load can happen in the same cycle, when a frame-start pulse coincides with a pixel strobe. The bench provokes this case several times, including on the step where the phase wraps from 3 back to 0. It also sends a frame-start pulse between two strobes, so that the two timings can be compared. In both cases the bit seen in the first sub-slot must match the advanced phase.

// File: rtl/dith_pkg.sv
package dith_pkg;
    localparam int SUBS = 4;
    localparam int PH_W = $clog2(SUBS);
    typedef logic [SUBS-1:0] pat_t;
    typedef logic [PH_W-1:0] ph_t;
endpackage

// File: rtl/dith_phase_ctr.sv
module dith_phase_ctr
    import dith_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    output ph_t  ph_q_o,
    output ph_t  ph_use_o
);
    typedef struct packed {
        ph_t ph;
    } ph_state_t;

    ph_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_start) begin
            s_d.ph = s_q.ph + ph_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // The phase for a pixel captured this cycle already includes a frame step.
    assign ph_q_o   = s_q.ph;
    assign ph_use_o = s_d.ph;
endmodule

// File: rtl/dith_pattern_enc.sv
module dith_pattern_enc
    import dith_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] lvl,
    input  ph_t              ph,
    output pat_t             pat
);
    always_comb begin
        pat = '0;
        if (lvl >= LVL_W'(SUBS)) begin
            pat = '1;
        end else if (lvl == LVL_W'(1)) begin
            pat = pat_t'(4'b1000) >> ph;
        end else if (lvl == LVL_W'(2)) begin
            pat = ph[0] ? pat_t'(4'b1010) : pat_t'(4'b0101);
        end else if (lvl == LVL_W'(3)) begin
            pat = ~(pat_t'(4'b0001) << ph);
        end
    end
endmodule

// File: rtl/dith_lane_ser.sv
module dith_lane_ser
    import dith_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  pat_t pat,
    output logic bit_o
);
    typedef struct packed {
        pat_t sh;
    } lane_state_t;

    lane_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sh = pat;
        end else begin
            s_d.sh = {s_q.sh[SUBS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_o = s_q.sh[SUBS-1];
endmodule

// File: rtl/dith_rgb_serializer.sv
module dith_rgb_serializer
    import dith_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_stb,
    input  logic             frame_start,
    input  logic [LVL_W-1:0] lvl_r,
    input  logic [LVL_W-1:0] lvl_g,
    input  logic [LVL_W-1:0] lvl_b,
    output logic             col_r,
    output logic             col_g,
    output logic             col_b
);
    localparam int NCH = 3;

    ph_t              ph_q;
    ph_t              ph_use;
    logic [LVL_W-1:0] lvl_arr [NCH];
    logic [NCH-1:0]   col_arr;

    assign lvl_arr[0] = lvl_r;
    assign lvl_arr[1] = lvl_g;
    assign lvl_arr[2] = lvl_b;

    dith_phase_ctr u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .ph_q_o      (ph_q),
        .ph_use_o    (ph_use)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        pat_t pat;

        dith_pattern_enc #(.LVL_W(LVL_W)) u_enc (
            .lvl (lvl_arr[ch]),
            .ph  (ph_use),
            .pat (pat)
        );

        dith_lane_ser u_ser (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (pix_stb),
            .pat   (pat),
            .bit_o (col_arr[ch])
        );
    end

    assign col_r = col_arr[0];
    assign col_g = col_arr[1];
    assign col_b = col_arr[2];
endmodule

// File: rtl/dith_rgb_serializer_chk.sv
module dith_rgb_serializer_chk
    import dith_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_stb,
    input logic             frame_start,
    input logic [LVL_W-1:0] lvl_r,
    input logic [LVL_W-1:0] lvl_g,
    input logic [LVL_W-1:0] lvl_b,
    input logic             col_r,
    input logic             col_g,
    input logic             col_b,
    input ph_t              ph_q
);
    logic [2:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= 3'd4;
        end else if (pix_stb) begin
            idle_cnt <= 3'd0;
        end else if (idle_cnt < 3'd4) begin
            idle_cnt <= idle_cnt + 3'd1;
        end
    end

    // Covers R1 as well: the counter starts saturated, so the lines are dark before the first strobe.
    p_idle_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt == 3'd4) |-> (!col_r && !col_g && !col_b));

    p_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && lvl_r == '0) |=> !col_r);

    p_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && lvl_g >= LVL_W'(SUBS)) |=> col_g);

    p_half_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && lvl_b == LVL_W'(2)) |=> ##1 (col_b != $past(col_b)));

    p_phase_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (ph_q == $past(ph_q) + ph_t'(1)));

    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && pix_stb && lvl_r == LVL_W'(1)) |=> (col_r == (ph_q == '0)));
endmodule

bind dith_rgb_serializer dith_rgb_serializer_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/tb_dith_rgb_serializer.sv
module tb_dith_rgb_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_stb = 1'b0;
    logic       frame_start = 1'b0;
    logic [2:0] lvl_r = '0;
    logic [2:0] lvl_g = '0;
    logic [2:0] lvl_b = '0;
    logic       col_r, col_g, col_b;

    int    n_tests = 0;
    int    n_fail = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;
    logic  first_r, first_g, first_b;

    int m_ph = 0;
    int m_sh [3] = '{0, 0, 0};

    always #5 clk = ~clk;

    dith_rgb_serializer dut (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .frame_start(frame_start),
        .lvl_r(lvl_r), .lvl_g(lvl_g), .lvl_b(lvl_b),
        .col_r(col_r), .col_g(col_g), .col_b(col_b)
    );

    function automatic int ref_pat(int l, int p);
        if (l == 0) return 0;
        if (l >= 4) return 15;
        if (l == 2) return (p % 2 == 1) ? 10 : 5;
        if (l == 1) begin
            case (p)
                0: return 8;
                1: return 4;
                2: return 2;
                default: return 1;
            endcase
        end
        case (p)
            0: return 14;
            1: return 13;
            2: return 11;
            default: return 7;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
            for (int c = 0; c < 3; c++) m_sh[c] = 0;
        end else begin
            if (frame_start) m_ph = (m_ph + 1) % 4;
            if (pix_stb) begin
                m_sh[0] = ref_pat(int'(lvl_r), m_ph);
                m_sh[1] = ref_pat(int'(lvl_g), m_ph);
                m_sh[2] = ref_pat(int'(lvl_b), m_ph);
            end else begin
                for (int c = 0; c < 3; c++) m_sh[c] = (m_sh[c] << 1) & 15;
            end
        end
    end

    task automatic check(string tag, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(cur_tag, col_r, logic'((m_sh[0] >> 3) & 1));
            check(cur_tag, col_g, logic'((m_sh[1] >> 3) & 1));
            check(cur_tag, col_b, logic'((m_sh[2] >> 3) & 1));
        end
    end

    task automatic pixel(int r, int g, int b, bit fs);
        @(negedge clk);
        pix_stb = 1'b1;
        frame_start = fs;
        lvl_r = r[2:0];
        lvl_g = g[2:0];
        lvl_b = b[2:0];
        @(negedge clk);
        pix_stb = 1'b0;
        frame_start = 1'b0;
        first_r = col_r;
        first_g = col_g;
        first_b = col_b;
        repeat (2) @(negedge clk);
    endtask

    task automatic lone_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        cur_tag = "R1";
        check("R1", col_r | col_g | col_b, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", col_r | col_g | col_b, 1'b0);

        cur_tag = "R4";
        pixel(1, 2, 3, 1'b0);
        check("R7", first_r, 1'b1);
        check("R5", first_g, 1'b0);
        check("R6", first_b, 1'b1);

        cur_tag = "R2";
        pixel(0, 4, 7, 1'b0);
        check("R2", first_r, 1'b0);
        check("R3", first_g, 1'b1);
        check("R3", first_b, 1'b1);

        cur_tag = "R8";
        lone_frame();
        pixel(1, 2, 3, 1'b0);
        check("R8", first_r, 1'b0);
        check("R8", first_g, 1'b1);

        cur_tag = "R9";
        pixel(1, 2, 3, 1'b1);
        check("R9", first_g, 1'b0);
        check("R9", first_b, 1'b1);
        cur_tag = "R6";
        pixel(1, 1, 3, 1'b1);
        check("R6", first_b, 1'b0);
        cur_tag = "R8";
        pixel(3, 1, 2, 1'b1);
        check("R8", first_g, 1'b1);
        check("R8", first_b, 1'b0);

        cur_tag = "R3";
        pixel(5, 6, 7, 1'b0);
        cur_tag = "R10";
        pixel(3, 0, 2, 1'b0);
        check("R10", first_g, 1'b0);

        cur_tag = "R11";
        repeat (10) @(negedge clk);
        check("R11", col_r | col_g | col_b, 1'b0);

        cur_tag = "R4";
        for (int f = 0; f < 6; f++) begin
            for (int l = 0; l < 8; l++) begin
                pixel(l, (l + 3) % 8, 7 - l, (l == 0));
            end
            if (f == 2) lone_frame();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R11: watchdog expired, got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule